// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block turns a peripheral clock into the 16x oversampling strobe that a UART transmitter and receiver use, plus a one-cycle bit strobe on every sixteenth oversampling strobe. The average spacing of the oversampling strobe is an integer divisor plus a fraction `dadd/mul`. The baud rate is therefore `f_clk / (16 * (div + dadd/mul))`.

A down-counter is reloaded with the integer divisor at each strobe. A small accumulator adds `dadd` at every strobe. Whenever it reaches `mul`, it wraps and the next period is one clock longer. Software sets the values through a four-address byte write port. The two divisor bytes can be written only while an access bit in a line-control register is set. Out-of-range settings are corrected inside the block, and a new setting is applied only at a period boundary.

Top module: `frac_baud_gen`

## Requirements
- R1: After a setting has been applied, any run of 16·MUL consecutive oversampling-strobe intervals sums to exactly 16·(DL·MUL + DADD) clock cycles. DL, DADD and MUL are the effective values.
- R2: With DADD = 0, every strobe interval is exactly DL cycles.
- R3: Address 0 writes divisor bits [7:0] and address 1 writes divisor bits [15:8]. Both writes take effect only while bit 7 of the line-control register (address 2) is 1. Otherwise they are ignored and the divisor keeps its value.
- R4: A write to address 3 loads DADD from data bits [7:4] and MUL from data bits [3:0].
- R5: A MUL of 0 is treated as 1. A DADD greater than or equal to the effective MUL is treated as MUL−1.
- R6: A divisor of 0 is treated as 1.
- R7: A setting written during a period takes effect only from the next period boundary. The period in progress keeps its original length.
- R8: `bit_tick_o` is a one-cycle pulse that coincides with every 16th pulse of `tick16_o` and never occurs without it.
- R9: Synchronous reset sets DL = 1, DADD = 0, MUL = 1, clears the access bit and the counters, and holds both outputs low. After release, the strobe occurs on every clock.
- R10: With DADD > 0, each individual interval is either DL or DL+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor low, 1 divisor high, 2 line control, 3 fraction |
| wr_data | input | 8 | Write data |
| tick16_o | output | 1 | One-cycle 16x oversampling strobe |
| bit_tick_o | output | 1 | One-cycle strobe on every 16th oversampling strobe |

## Verification
The divider is exercised with settings that separate its mechanisms:
- Pure integer divisors, including 1 and a value that needs the high byte, show that the count is exact and that no fraction leaks in.
- Fractions such as 3/4, 1/2, 11/15 and 14/15 show that the accumulator spreads the extra cycles so that each interval is DL or DL+1. Their window totals show that exactly DADD extra cycles fall in every MUL periods.
- The zero and over-range settings are expected to give exactly the totals of their corrected values, which separates correction from raw use.
- Directed cases check the following: a divisor write while access is off, where the period must not change; a divisor change in the middle of a long period, where the old period must complete before the new one starts; and the reset state.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

   typedef enum logic [1:0] {
      ADDR_DIV_LO = 2'd0,
      ADDR_DIV_HI = 2'd1,
      ADDR_LINE   = 2'd2,
      ADDR_FRAC   = 2'd3
   } reg_addr_e;

   // bit of the line-control byte that opens the divisor bytes
   localparam int ACCESS_BIT = 7;
   // position of the add value inside the fraction byte
   localparam int DADD_LSB   = 4;

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
   import frac_baud_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [7:0]        wr_data,
   output logic [DIV_W-1:0]  dl_eff_o,
   output logic [FRAC_W-1:0] dadd_eff_o,
   output logic [FRAC_W-1:0] mul_eff_o,
   output logic [DIV_W-1:0]  dl_raw_o,
   output logic              access_o
);

   localparam int HI_W = DIV_W - 8;

   logic              access_q;
   logic [DIV_W-1:0]  dl_q;
   logic [FRAC_W-1:0] dadd_q;
   logic [FRAC_W-1:0] mul_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         access_q <= 1'b0;
         dl_q     <= DIV_W'(1);
         dadd_q   <= '0;
         mul_q    <= FRAC_W'(1);
      end else if (wr_en) begin
         unique case (reg_addr_e'(wr_addr))
            ADDR_DIV_LO: if (access_q) dl_q[7:0] <= wr_data;
            ADDR_DIV_HI: if (access_q) dl_q[DIV_W-1:8] <= wr_data[HI_W-1:0];
            ADDR_LINE:   access_q <= wr_data[ACCESS_BIT];
            ADDR_FRAC: begin
               dadd_q <= wr_data[DADD_LSB +: FRAC_W];
               mul_q  <= wr_data[0 +: FRAC_W];
            end
            default: ;
         endcase
      end
   end

   // correction of out-of-range settings
   always_comb begin
      mul_eff_o  = (mul_q == '0) ? FRAC_W'(1) : mul_q;
      dadd_eff_o = (dadd_q >= mul_eff_o) ? (mul_eff_o - FRAC_W'(1)) : dadd_q;
      dl_eff_o   = (dl_q == '0) ? DIV_W'(1) : dl_q;
   end

   assign dl_raw_o = dl_q;
   assign access_o = access_q;

endmodule

// File: rtl/frac_baud_core.sv
module frac_baud_core #(
   parameter int DIV_W   = 16,
   parameter int FRAC_W  = 4,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DIV_W-1:0]  dl_i,
   input  logic [FRAC_W-1:0] dadd_i,
   input  logic [FRAC_W-1:0] mul_i,
   output logic              strobe_o,
   output logic [FRAC_W-1:0] acc_o,
   output logic [FRAC_W-1:0] mul_act_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             stretch;

   // the period ends when the remaining count reaches zero
   assign strobe_o = (cnt_q == '0);

   generate
      if (FRAC_EN) begin : g_frac
         logic [FRAC_W-1:0] acc_q;
         logic [FRAC_W-1:0] dadd_act_q;
         logic [FRAC_W-1:0] mul_act_q;
         logic [FRAC_W-1:0] base;
         logic [FRAC_W:0]   sum;
         logic              restart;

         always_comb begin
            restart = (dadd_i != dadd_act_q) || (mul_i != mul_act_q);
            base    = restart ? '0 : acc_q;
            sum     = {1'b0, base} + {1'b0, dadd_i};
            stretch = (sum >= {1'b0, mul_i});
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               acc_q      <= '0;
               dadd_act_q <= '0;
               mul_act_q  <= FRAC_W'(1);
            end else if (strobe_o) begin
               acc_q      <= stretch ? FRAC_W'(sum - {1'b0, mul_i}) : sum[FRAC_W-1:0];
               dadd_act_q <= dadd_i;
               mul_act_q  <= mul_i;
            end
         end

         assign acc_o     = acc_q;
         assign mul_act_o = mul_act_q;
      end else begin : g_int
         logic unused_frac;
         assign unused_frac = ^{dadd_i, mul_i};
         assign stretch     = 1'b0;
         assign acc_o       = '0;
         assign mul_act_o   = FRAC_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (strobe_o)
         cnt_q <= dl_i - DIV_W'(1) + {{(DIV_W-1){1'b0}}, stretch};
      else
         cnt_q <= cnt_q - DIV_W'(1);
   end

endmodule

// File: rtl/frac_baud_bitdiv.sv
module frac_baud_bitdiv #(
   parameter int OVS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic strobe_i,
   output logic tick16_o,
   output logic bit_tick_o
);

   localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [CW-1:0] LAST = CW'(OVS - 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nx;
   logic          last;

   assign last = (cnt_q == LAST);

   generate
      if ((OVS & (OVS - 1)) == 0) begin : g_pow2
         assign cnt_nx = cnt_q + CW'(1);
      end else begin : g_any
         assign cnt_nx = last ? '0 : cnt_q + CW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q      <= '0;
         tick16_o   <= 1'b0;
         bit_tick_o <= 1'b0;
      end else begin
         tick16_o   <= strobe_i;
         bit_tick_o <= strobe_i && last;
         if (strobe_i) cnt_q <= cnt_nx;
      end
   end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
   parameter int DIV_W   = 16,
   parameter int FRAC_W  = 4,
   parameter int OVS     = 16,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       tick16_o,
   output logic       bit_tick_o
);

   generate
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
         $error("frac_baud_gen: DIV_W must lie in 9..16");
      end
      if (FRAC_W < 1 || FRAC_W > 4) begin : g_bad_frac
         $error("frac_baud_gen: FRAC_W must lie in 1..4");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("frac_baud_gen: OVS must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0]  dl_eff;
   logic [DIV_W-1:0]  dl_raw;
   logic [FRAC_W-1:0] dadd_eff;
   logic [FRAC_W-1:0] mul_eff;
   logic [FRAC_W-1:0] acc_val;
   logic [FRAC_W-1:0] mul_act;
   logic              access;
   logic              strobe;

   frac_baud_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .dl_eff_o   (dl_eff),
      .dadd_eff_o (dadd_eff),
      .mul_eff_o  (mul_eff),
      .dl_raw_o   (dl_raw),
      .access_o   (access)
   );

   frac_baud_core #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .FRAC_EN(FRAC_EN)) u_core (
      .clk       (clk),
      .rst       (rst),
      .dl_i      (dl_eff),
      .dadd_i    (dadd_eff),
      .mul_i     (mul_eff),
      .strobe_o  (strobe),
      .acc_o     (acc_val),
      .mul_act_o (mul_act)
   );

   frac_baud_bitdiv #(.OVS(OVS)) u_bitdiv (
      .clk        (clk),
      .rst        (rst),
      .strobe_i   (strobe),
      .tick16_o   (tick16_o),
      .bit_tick_o (bit_tick_o)
   );

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
   parameter int DIV_W  = 16,
   parameter int FRAC_W = 4,
   parameter int OVS    = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic [7:0]        wr_data,
   input logic              tick16_o,
   input logic              bit_tick_o,
   input logic [DIV_W-1:0]  dl_raw,
   input logic              access,
   input logic [FRAC_W-1:0] acc_val,
   input logic [FRAC_W-1:0] mul_act
);

   localparam int CW = $clog2(OVS) + 1;
   logic [CW-1:0] ticks_since_bit;

   always_ff @(posedge clk) begin
      if (rst)
         ticks_since_bit <= '0;
      else if (bit_tick_o)
         ticks_since_bit <= '0;
      else if (tick16_o)
         ticks_since_bit <= ticks_since_bit + CW'(1);
   end

   // R8
   bit_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
      bit_tick_o |-> tick16_o);

   // R8
   bit_period_chk: assert property (@(posedge clk) disable iff (rst)
      bit_tick_o |-> (ticks_since_bit == CW'(OVS - 1)));

   // R3
   blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !access && (wr_addr == 2'd0 || wr_addr == 2'd1)) |=> $stable(dl_raw));

   // R3
   open_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && access && wr_addr == 2'd0) |=> (dl_raw[7:0] == $past(wr_data)));

   // R10
   acc_range_chk: assert property (@(posedge clk) disable iff (rst)
      acc_val < mul_act);

   // R9
   reset_value_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (dl_raw == DIV_W'(1) && !access && !tick16_o && !bit_tick_o));

endmodule

bind frac_baud_gen frac_baud_chk #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OVS(OVS)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .tick16_o   (tick16_o),
   .bit_tick_o (bit_tick_o),
   .dl_raw     (dl_raw),
   .access     (access),
   .acc_val    (acc_val),
   .mul_act    (mul_act)
);

// File: tb/frac_baud_gen_tb_top.sv
module frac_baud_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tick16;
   logic       bit_tick;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int strays = 0;

   always #4 clk = ~clk;   // 125 MHz
   always @(posedge clk) cyc <= cyc + 1;

   frac_baud_gen dut_i (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .tick16_o   (tick16),
      .bit_tick_o (bit_tick)
   );

   typedef struct packed {
      logic [15:0] dl;
      logic [3:0]  dv;
      logic [3:0]  ml;
      logic [15:0] edl;
      logic [3:0]  edv;
      logic [3:0]  eml;
      logic [1:0]  kind;   // 0 plain, 1 fraction correction (R5), 2 zero divisor (R6)
      int unsigned total;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{16'd10,  4'd3,  4'd4,  16'd10,  4'd3,  4'd4,  2'd0, 688},
      '{16'd1,   4'd0,  4'd1,  16'd1,   4'd0,  4'd1,  2'd0, 16},
      '{16'd5,   4'd0,  4'd1,  16'd5,   4'd0,  4'd1,  2'd0, 80},
      '{16'd3,   4'd1,  4'd2,  16'd3,   4'd1,  4'd2,  2'd0, 112},
      '{16'd7,   4'd11, 4'd15, 16'd7,   4'd11, 4'd15, 2'd0, 1856},
      '{16'd2,   4'd14, 4'd15, 16'd2,   4'd14, 4'd15, 2'd0, 704},
      '{16'd300, 4'd1,  4'd3,  16'd300, 4'd1,  4'd3,  2'd0, 14416},
      '{16'd258, 4'd0,  4'd1,  16'd258, 4'd0,  4'd1,  2'd0, 4128},
      '{16'd4,   4'd0,  4'd0,  16'd4,   4'd0,  4'd1,  2'd1, 64},
      '{16'd2,   4'd9,  4'd4,  16'd2,   4'd3,  4'd4,  2'd1, 176},
      '{16'd6,   4'd5,  4'd5,  16'd6,   4'd4,  4'd5,  2'd1, 544},
      '{16'd0,   4'd0,  4'd1,  16'd1,   4'd0,  4'd1,  2'd2, 16}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_div(input logic [15:0] dl);
      wr(2'd2, 8'h83);
      wr(2'd0, dl[7:0]);
      wr(2'd1, dl[15:8]);
      wr(2'd2, 8'h03);
   endtask

   task automatic next_tick(output int at);
      forever begin
         @(negedge clk);
         if (bit_tick && !tick16) strays++;
         if (tick16) begin
            at = cyc;
            break;
         end
      end
   endtask

   task automatic measure(input int n, output int total, output int mn,
                          output int mx, output int bits);
      int last, now;
      total = 0; mn = 32'h7fffffff; mx = 0; bits = 0;
      next_tick(last);
      for (int i = 0; i < n; i++) begin
         next_tick(now);
         if (bit_tick) bits++;
         total += now - last;
         if (now - last < mn) mn = now - last;
         if (now - last > mx) mx = now - last;
         last = now;
      end
   endtask

   function automatic string req_of(input logic [1:0] kind);
      return (kind == 2'd1) ? "R5" : (kind == 2'd2) ? "R6" : "R1";
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int total, mn, mx, bits, t0, t1, t2;

      // R9: outputs stay low while reset is held
      repeat (3) @(negedge clk);
      check(!tick16 && !bit_tick, "R9 outputs in reset", {tick16, bit_tick}, 0);
      rst = 1'b0;

      // R9: default divisor 1 gives a strobe on every clock
      measure(16, total, mn, mx, bits);
      check(total == 16, "R9 default period", total, 16);
      check(bits == 1, "R8 bit count after reset", bits, 1);

      // R1 R2 R4 R5 R6 R8 R10 from the vector table
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         int unsigned n;
         v = VECS[i];
         set_div(v.dl);
         wr(2'd3, {v.dv, v.ml});   // R4: add value in [7:4], multiplier in [3:0]
         next_tick(t0);
         next_tick(t0);
         n = 16 * int'(v.eml);
         strays = 0;
         measure(int'(n), total, mn, mx, bits);
         check(total == int'(v.total), req_of(v.kind), total, int'(v.total));
         check(bits == int'(v.eml) && strays == 0, "R8 bit ticks", bits, int'(v.eml));
         if (v.edv == 0)
            check(mn == int'(v.edl) && mx == int'(v.edl), "R2 integer interval",
                  mx, int'(v.edl));
         else
            check(mn == int'(v.edl) && mx == int'(v.edl) + 1, "R10 interval spread",
                  mx, int'(v.edl) + 1);
      end

      // R3: divisor writes with the access bit clear are ignored
      set_div(16'd20);
      wr(2'd3, 8'h01);
      wr(2'd2, 8'h03);
      wr(2'd0, 8'd5);
      wr(2'd1, 8'd1);
      next_tick(t0);
      next_tick(t0);
      measure(16, total, mn, mx, bits);
      check(total == 320 && mn == 20, "R3 locked divisor", total, 320);

      // R7: a change in the middle of a period waits for the boundary
      set_div(16'd200);
      next_tick(t0);
      next_tick(t0);
      repeat (50) @(negedge clk);
      set_div(16'd20);
      next_tick(t1);
      check(t1 - t0 == 200, "R7 period in progress", t1 - t0, 200);
      next_tick(t2);
      check(t2 - t1 == 20, "R7 new period", t2 - t1, 20);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule